// File: doc/BRIEF.md
# VGA Colorspace Scaler with Sync Regeneration

This block sits between four 8-bit output channels of a pixel streamer and the pins that drive a VGA connector. Channels 3, 2 and 1 carry red, green and blue; channel 0 carries the horizontal sync level. In VGA mode each colour output is a weighted sum of the three incoming colour bytes. Three 32-bit coefficient words supply the weights, one word per output colour. The fourth channel is rebuilt as a clean full-scale sync level, and its polarity can be chosen. In pass-through mode all four channels leave the block unchanged.

The pipeline accepts a new sample on every clock and has a fixed latency of two clocks in every mode. Switching modes therefore never shifts the picture in time. The mode word and the coefficient words are captured together with each input sample and travel with it. A configuration change applies to the next sample that enters and never to samples already inside the pipeline.

Top module: `vga_color_scaler`

## Requirements
- R1: `out_valid` is 0 while `rst_n` is low and in the first cycles after reset. It equals `in_valid` delayed by exactly two clocks.
- R2: When `cfg_mode[6:5]` is 2'b00, `out_chan` equals `in_chan` from two clocks earlier, with all four bytes unchanged.
- R3: When `cfg_mode[6:5]` is 2'b10 or 2'b11, the block also passes all four channels unchanged.
- R4: When `cfg_mode[6:5]` is 2'b01 (VGA mode), each colour output is computed as floor((wR*R + wG*G + wB*B) / 128). The inputs R, G and B are `in_chan` bytes [31:24], [23:16] and [15:8]. The weights wR, wG and wB are signed two's-complement bytes [31:24], [23:16] and [15:8] of the coefficient word. `coef_r` drives output byte [31:24], `coef_g` drives byte [23:16] and `coef_b` drives byte [15:8].
- R5: In VGA mode a colour result above 255 is clamped to 255, and a negative result is clamped to 0.
- R6: In VGA mode a weight of 80 on a channel's own colour, with the other weights 0, gives floor(80*x/128) on that channel.
- R7: In VGA mode, `out_chan[7:0]` is 8'hFF when `in_chan[7:0]` is nonzero and 8'h00 when it is zero. When `cfg_mode[4]` is 1, this result is inverted.
- R8: Each sample is processed with the `cfg_mode`, `coef_r`, `coef_g` and `coef_b` values present in the cycle it enters. A change in the following cycle has no effect on it.
- R9: Samples entering on consecutive clocks each produce their own correct result on consecutive clocks.
- R10: `cfg_mode[3:0]` and byte [7:0] of each coefficient word have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 7 | Mode word: [6:5] mode, [4] sync invert, [3:0] unused |
| coef_r | input | 32 | Weights for the red output |
| coef_g | input | 32 | Weights for the green output |
| coef_b | input | 32 | Weights for the blue output |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 32 | Four input channels, channel 3 in [31:24] |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 32 | Four output channels, channel 3 in [31:24] |

## Verification
On every cycle, the assertions check the following:
- the two-clock valid latency;
- exact pass-through in the non-VGA modes;
- that the sync byte is always full-scale or zero with the correct polarity;
- that black input stays black.

The weighted sums, both clamp directions, signed weights and per-sample capture of the configuration rely on arithmetic the assertions do not repeat. Only the bench's sweeps can show them: swept input bytes, weights over all 256 values, and configuration that changes on every cycle.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    localparam int MODE_W       = 7;
    localparam int MODE_HI      = 6;
    localparam int MODE_LO      = 5;
    localparam int SYNC_POL_BIT = 4;
    localparam int NUM_CH       = 4;
    localparam int NUM_COLOR    = 3;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_VGA   = 2'b01,
        MODE_RSV_A = 2'b10,
        MODE_RSV_B = 2'b11
    } vcs_mode_e;
endpackage

// File: rtl/vcs_weight_row.sv
// One output colour: three signed weight x unsigned pixel products.
module vcs_weight_row import vcs_pkg::*; #(
    parameter int CH_W = 8
) (
    input  logic [NUM_CH*CH_W-1:0]          coef,
    input  logic [NUM_CH*CH_W-1:0]          pix,
    output logic [NUM_COLOR*(2*CH_W+1)-1:0] prod
);
    localparam int PW = 2 * CH_W + 1;

    for (genvar c = 0; c < NUM_COLOR; c++) begin : g_col
        localparam int CH = NUM_CH - 1 - c;
        logic signed [PW-1:0] w_ext;
        logic signed [PW-1:0] p_ext;
        logic signed [PW-1:0] prod_c;
        always_comb begin
            w_ext  = PW'($signed(coef[CH*CH_W +: CH_W]));
            p_ext  = PW'($signed({1'b0, pix[CH*CH_W +: CH_W]}));
            prod_c = w_ext * p_ext;
        end
        assign prod[c*PW +: PW] = prod_c;
    end
endmodule

// File: rtl/vcs_sum_clamp.sv
// Adds three products, drops the fraction (floor) and clamps to the channel range.
module vcs_sum_clamp import vcs_pkg::*; #(
    parameter int CH_W = 8
) (
    input  logic [NUM_COLOR*(2*CH_W+1)-1:0] prod,
    output logic [CH_W-1:0]                 level
);
    localparam int PW   = 2 * CH_W + 1;
    localparam int SW   = PW + 2;
    localparam int FRAC = CH_W - 1;
    localparam int MAXV = (1 << CH_W) - 1;

    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] shifted;

    always_comb begin
        acc = '0;
        for (int c = 0; c < NUM_COLOR; c++) begin
            acc = acc + SW'($signed(prod[c*PW +: PW]));
        end
        shifted = acc >>> FRAC;
        if (shifted[SW-1]) begin
            level = '0;
        end else if (shifted > $signed(SW'(MAXV))) begin
            level = '1;
        end else begin
            level = shifted[CH_W-1:0];
        end
    end
endmodule

// File: rtl/vcs_sync_gen.sv
// Rebuilds the sync channel as a full-scale level with selectable polarity.
module vcs_sync_gen #(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0] raw,
    input  logic            invert,
    output logic [CH_W-1:0] level
);
    always_comb begin
        level = ((|raw) ^ invert) ? '1 : '0;
    end
endmodule

// File: rtl/vga_color_scaler.sv
module vga_color_scaler import vcs_pkg::*; #(
    parameter int CH_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [MODE_W-1:0]        cfg_mode,
    input  logic [NUM_CH*CH_W-1:0]   coef_r,
    input  logic [NUM_CH*CH_W-1:0]   coef_g,
    input  logic [NUM_CH*CH_W-1:0]   coef_b,
    input  logic                     in_valid,
    input  logic [NUM_CH*CH_W-1:0]   in_chan,
    output logic                     out_valid,
    output logic [NUM_CH*CH_W-1:0]   out_chan
);
    localparam int DW   = NUM_CH * CH_W;
    localparam int PW   = 2 * CH_W + 1;
    localparam int ROWW = NUM_COLOR * PW;

    typedef struct packed {
        logic                      valid;
        logic                      vga;
        logic [DW-1:0]             raw;
        logic [CH_W-1:0]           sync;
        logic [NUM_COLOR*ROWW-1:0] prod;
    } s1_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } st_t;

    st_t st_d, st_q;

    logic [DW-1:0]             coef_row [NUM_COLOR];
    logic [NUM_COLOR*ROWW-1:0] prod_now;
    logic [CH_W-1:0]           sync_now;
    logic [NUM_COLOR*CH_W-1:0] level_s2;

    assign coef_row[0] = coef_r;
    assign coef_row[1] = coef_g;
    assign coef_row[2] = coef_b;

    // Stage 1: products, computed against the configuration of this sample.
    for (genvar k = 0; k < NUM_COLOR; k++) begin : g_row
        vcs_weight_row #(.CH_W(CH_W)) u_row (
            .coef (coef_row[k]),
            .pix  (in_chan),
            .prod (prod_now[k*ROWW +: ROWW])
        );
    end

    vcs_sync_gen #(.CH_W(CH_W)) u_sync (
        .raw    (in_chan[CH_W-1:0]),
        .invert (cfg_mode[SYNC_POL_BIT]),
        .level  (sync_now)
    );

    // Stage 2: sum and clamp from registered products.
    for (genvar k = 0; k < NUM_COLOR; k++) begin : g_sum
        vcs_sum_clamp #(.CH_W(CH_W)) u_sum (
            .prod  (st_q.s1.prod[k*ROWW +: ROWW]),
            .level (level_s2[k*CH_W +: CH_W])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.s1.valid = in_valid;
        st_d.s1.vga   = (vcs_mode_e'(cfg_mode[MODE_HI:MODE_LO]) == MODE_VGA);
        st_d.s1.raw   = in_chan;
        st_d.s1.sync  = sync_now;
        st_d.s1.prod  = prod_now;

        st_d.s2.valid = st_q.s1.valid;
        if (st_q.s1.vga) begin
            for (int k = 0; k < NUM_COLOR; k++) begin
                st_d.s2.data[(NUM_CH-1-k)*CH_W +: CH_W] = level_s2[k*CH_W +: CH_W];
            end
            st_d.s2.data[CH_W-1:0] = st_q.s1.sync;
        end else begin
            st_d.s2.data = st_q.s1.raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.s2.valid;
    assign out_chan  = st_q.s2.data;
endmodule

// File: rtl/vga_color_scaler_chk.sv
module vga_color_scaler_chk import vcs_pkg::*; #(
    parameter int CH_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [MODE_W-1:0]      cfg_mode,
    input logic                   in_valid,
    input logic [NUM_CH*CH_W-1:0] in_chan,
    input logic                   out_valid,
    input logic [NUM_CH*CH_W-1:0] out_chan
);
    localparam int DW = NUM_CH * CH_W;

    logic [1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd2) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    // R1: nothing valid leaves right after reset
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd0) |-> !out_valid);

    // R1: two-clock valid latency
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2 / R3: non-VGA modes pass data unchanged
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2 && $past(in_valid, 2) &&
         $past(cfg_mode[MODE_HI:MODE_LO], 2) != 2'b01)
        |-> (out_chan == $past(in_chan, 2)));

    // R7: sync byte is full-scale or zero with the selected polarity
    p_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2 && $past(in_valid, 2) &&
         $past(cfg_mode[MODE_HI:MODE_LO], 2) == 2'b01)
        |-> (out_chan[CH_W-1:0] ==
             ((($past(in_chan[CH_W-1:0], 2) != '0) ^ $past(cfg_mode[SYNC_POL_BIT], 2))
              ? {CH_W{1'b1}} : {CH_W{1'b0}})));

    // R4: black input gives black colour outputs for any weights
    p_black_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd2 && $past(in_valid, 2) &&
         $past(cfg_mode[MODE_HI:MODE_LO], 2) == 2'b01 &&
         $past(in_chan[DW-1:CH_W], 2) == '0)
        |-> (out_chan[DW-1:CH_W] == '0));
endmodule

bind vga_color_scaler vga_color_scaler_chk #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .out_valid (out_valid),
    .out_chan  (out_chan)
);

// File: tb/vga_color_scaler_test.sv
module vga_color_scaler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_mode = '0;
    logic [31:0] coef_r = '0, coef_g = '0, coef_b = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_chan = '0;
    logic        out_valid;
    logic [31:0] out_chan;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // slot0: driven last step, slot1: driven two steps ago
    bit          live0 = 0, live1 = 0;
    bit          pv0 = 0, pv1 = 0;
    logic [31:0] pd0 = '0, pd1 = '0;
    string       pt0 = "", pt1 = "";

    always #4 clk = ~clk;

    vga_color_scaler uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .coef_r(coef_r), .coef_g(coef_g), .coef_b(coef_b),
        .in_valid(in_valid), .in_chan(in_chan),
        .out_valid(out_valid), .out_chan(out_chan)
    );

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [31:0] model(logic [31:0] d, logic [6:0] m,
                                          logic [31:0] cr, logic [31:0] cg, logic [31:0] cb);
        logic [31:0] res;
        logic [31:0] cf [3];
        int acc, w, x, v;
        if (m[6:5] != 2'b01) return d;
        cf[0] = cr; cf[1] = cg; cf[2] = cb;
        res = '0;
        for (int k = 0; k < 3; k++) begin
            acc = 0;
            for (int c = 0; c < 3; c++) begin
                w = int'($signed(cf[k][(3-c)*8 +: 8]));
                x = int'(cf[k][7:0] & 8'h00) + int'(d[(3-c)*8 +: 8]);
                acc = acc + w * x;
            end
            v = acc >>> 7;
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            res[(3-k)*8 +: 8] = v[7:0];
        end
        res[7:0] = ((d[7:0] != 8'd0) ^ m[4]) ? 8'hFF : 8'h00;
        return res;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] d, input logic [6:0] m,
                        input logic [31:0] cr, input logic [31:0] cg, input logic [31:0] cb,
                        input string tag);
        @(negedge clk);
        if (live1) begin
            check(out_valid == pv1, {pt1, " valid"}, {31'd0, out_valid}, {31'd0, pv1});
            if (pv1) check(out_chan == pd1, pt1, out_chan, pd1);
        end
        live1 = live0; pv1 = pv0; pd1 = pd0; pt1 = pt0;
        live0 = 1'b1; pv0 = v; pd0 = model(d, m, cr, cg, cb); pt0 = tag;
        in_valid = v; in_chan = d; cfg_mode = m;
        coef_r = cr; coef_g = cg; coef_b = cb;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c;
        logic [6:0]  m;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 reset valid", {31'd0, out_valid}, 32'd0);
        check(out_chan == 32'd0, "R1 reset data", out_chan, 32'd0);
        rst_n = 1'b1;

        // R2, R10: pass-through with unused mode bits toggling
        for (int i = 0; i < 40; i++) begin
            a = rnd();
            step(1'b1, a, {2'b00, a[4], a[3:0]}, rnd(), rnd(), rnd(), "R2 bypass");
        end
        // R3: reserved modes pass through
        for (int i = 0; i < 40; i++) begin
            a = rnd();
            step(1'b1, a, {(i % 2 == 0) ? 2'b10 : 2'b11, a[9:5]}, rnd(), rnd(), rnd(), "R3 reserved");
        end
        // R6: 80/128 scaling, R input swept exhaustively, G and B derived
        for (int i = 0; i < 256; i++) begin
            a = {i[7:0], 8'(255 - i), 8'(i * 7), 8'h00};
            step(1'b1, a, 7'b0100000, 32'd80 << 24, 32'd80 << 16, 32'd80 << 8, "R6 scale80");
        end
        // R5: weight byte swept across all signed values with full-scale input
        for (int i = 0; i < 256; i++) begin
            step(1'b1, 32'hFFFF_FF01, 7'b0100000,
                 {i[7:0], 8'd127, 8'd0, 8'd0}, {8'd0, i[7:0], 8'd0, 8'd0},
                 {8'd0, 8'd0, i[7:0], 8'd0}, "R5 clamp");
        end
        // R4: random mixes of signed weights and pixels
        for (int i = 0; i < 300; i++) begin
            step(1'b1, rnd(), 7'b0100000, rnd() & 32'hFFFF_FF00,
                 rnd() & 32'hFFFF_FF00, rnd() & 32'hFFFF_FF00, "R4 weighted");
        end
        // R7: sync byte swept for both polarities
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 256; i++) begin
                step(1'b1, {24'h406080, i[7:0]}, {2'b01, p[0], 4'b0000},
                     32'd100 << 24, 32'd100 << 16, 32'd100 << 8, "R7 sync");
            end
        end
        // R8, R9: configuration changes every back-to-back cycle
        for (int i = 0; i < 300; i++) begin
            a = rnd(); b = rnd(); c = rnd();
            m = {(i % 3 == 0) ? 2'b00 : 2'b01, b[0], 4'b0000};
            step(1'b1, rnd(), m, a, b, c, (i % 2 == 0) ? "R8 cfg_change" : "R9 back2back");
        end
        // R1: valid with idle gaps
        for (int i = 0; i < 100; i++) begin
            a = rnd();
            step(a[0] & a[3], rnd(), {a[5] ? 2'b01 : 2'b00, a[6], 4'b0}, rnd(), rnd(), rnd(), "R1 gaps");
        end
        // R10: unused mode bits and coefficient low bytes in VGA mode
        for (int i = 0; i < 200; i++) begin
            a = rnd();
            step(1'b1, rnd(), {2'b01, a[4], a[3:0]}, rnd(), rnd(), rnd(), "R10 ignored");
        end
        for (int i = 0; i < 3; i++) step(1'b0, 32'd0, 7'd0, 32'd0, 32'd0, 32'd0, "R1 drain");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule